// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot control and slot status registers of a hot-plug capable downstream or root port. Configuration software reaches both registers through a single 32-bit write port with byte enables. The control register sits in bytes 0-1 and the status register sits in bytes 2-3. Hardware event inputs mark status bits: a button press, a presence change, and a device arrival. Every control write completes at once and reports command completion. Writing the interlock-control bit flips the interlock status. A power-off command on a populated slot requests detachment of the device.

The block combines the enabled status events into one notification level. In legacy mode it drives that level on an interrupt line. In message mode it pulses a one-cycle request on every change of the level, and the request carries a fixed vector number. Physical power sequencing, the interlock mechanism and message formation all belong to neighbouring logic.

Top module: `hp_slot_ctrl`

## Requirements
- R1: A write with either of byte enables 0-1 set is one command. On the clock edge that applies the write, status bit 4 (command completed, read bit 20) becomes 1.
- R2: Writing 1 to control bit 11 (byte 1 enabled) inverts status bit 7 (interlock status, read bit 23) on that edge. Control bit 11 always reads 0.
- R3: The notification level is control bit 5 AND any of (status AND control) over bits 0, 3 and 4. In legacy mode (msgMode=0), intLegacy takes a changed level one clock edge after the register update.
- R4: In message mode (msgMode=1), each change of the notification level gives msgReq high for exactly one cycle, one edge after the register update. msgVector carries MSG_VEC. intLegacy does not change while msgMode is 1.
- R5: Setting a status event bit that is already 1 causes no msgReq pulse.
- R6: The detach action needs three things: status bit 6 (present) is 1, and the resulting control value has bit 10 = 1 and bits 9:8 = 2'b11. The action then pulses detachReq for one cycle, clears status bit 6 and linkActive, and sets status bit 3, all on the write's edge.
- R7: The reset is synchronous. Control comes out with bits 7:6 = 2'b11 and all enables at 0. With devPresent=1, bits 9:8 = 2'b01 and bit 10 = 0; with devPresent=0, bits 9:8 = 2'b11 and bit 10 = 1. Status is 0 apart from bit 6, which equals devPresent. linkActive equals devPresent, and intLegacy, msgReq and detachReq are 0.
- R8: Status bits 0, 3 and 4 are write-1-to-clear through byte 2; other status bits ignore writes. If a status write leaves the notification level false in legacy mode, intLegacy is 0 one edge later.
- R9: A devAdd pulse sets status bits 6, 3 and 0 and sets linkActive.
- R10: btnPress sets status bit 0, and presChange sets status bit 3.
- R11: Control bytes whose byte enable is 0 keep their value. Writable control bits are 0, 3-10 (bit 10 only with a power controller); all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| devPresent | input | 1 | Slot occupancy, sampled during reset |
| wrEn | input | 1 | Configuration write strobe |
| wrData | input | 32 | Write data: control in 15:0, status in 31:16 |
| wrBe | input | 4 | Byte enables for wrData |
| btnPress | input | 1 | Attention button event pulse |
| presChange | input | 1 | Presence change event pulse |
| devAdd | input | 1 | Device arrival event pulse |
| msgMode | input | 1 | 1 selects message requests, 0 the legacy line |
| rdData | output | 32 | Current {status, control} |
| intLegacy | output | 1 | Legacy interrupt level |
| msgReq | output | 1 | One-cycle message request |
| msgVector | output | 5 | Vector number carried with msgReq |
| detachReq | output | 1 | One-cycle device detach request |
| linkActive | output | 1 | Data link active status |

## Verification
The bench uses the default build: a power controller present, link reporting enabled and MSG_VEC = 9. The power controller puts the power-off detach path and both populated-dependent reset encodings within reach. Link reporting makes the link clear on detach visible at a port. The non-zero vector shows that msgVector carries the parameter and not a constant zero.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int REG_W  = 16;
  localparam int DATA_W = 2 * REG_W;
  localparam int BE_W   = DATA_W / 8;

  // control bit positions
  localparam int CT_ABPE = 0;
  localparam int CT_PDCE = 3;
  localparam int CT_CCIE = 4;
  localparam int CT_HPIE = 5;
  localparam int CT_AI_LO = 6;
  localparam int CT_PI_LO = 8;
  localparam int CT_PCC  = 10;
  localparam int CT_EIC  = 11;

  // status bit positions
  localparam int ST_ABP = 0;
  localparam int ST_PDC = 3;
  localparam int ST_CC  = 4;
  localparam int ST_PDS = 6;
  localparam int ST_EIS = 7;

  localparam logic [1:0] IND_ON  = 2'b01;
  localparam logic [1:0] IND_OFF = 2'b11;

  // events that can raise a notification; enables share the positions
  localparam logic [REG_W-1:0] EV_MASK =
    (REG_W'(1) << ST_ABP) | (REG_W'(1) << ST_PDC) | (REG_W'(1) << ST_CC);

  typedef struct packed {
    logic             ctrlLoad;
    logic [REG_W-1:0] ctrlVal;
    logic [REG_W-1:0] statClr;
    logic             eisFlip;
    logic             detach;
    logic             cmdDone;
    logic             setAbp;
    logic             setPdc;
    logic             setPds;
  } hpStrobe_t;
endpackage

// File: rtl/hp_slot_dp.sv
module hp_slot_dp
  import hp_slot_pkg::*;
#(
  parameter bit HAS_PWR_CTL  = 1'b1,
  parameter bit HAS_LINK_RPT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             devPresent,
  input  hpStrobe_t        stb,
  output logic [REG_W-1:0] ctrlQ,
  output logic [REG_W-1:0] statQ,
  output logic             linkActive,
  output logic             detachReq
);
  localparam logic [REG_W-1:0] AI_OFF_BITS = REG_W'(IND_OFF) << CT_AI_LO;
  localparam logic [REG_W-1:0] CTRL_RST_FULL = HAS_PWR_CTL ?
    (AI_OFF_BITS | (REG_W'(IND_ON) << CT_PI_LO)) : AI_OFF_BITS;
  localparam logic [REG_W-1:0] CTRL_RST_EMPTY = HAS_PWR_CTL ?
    (AI_OFF_BITS | (REG_W'(IND_OFF) << CT_PI_LO) | (REG_W'(1) << CT_PCC)) : AI_OFF_BITS;

  logic [REG_W-1:0] statNext;

  always_comb begin
    statNext = statQ & ~stb.statClr;
    if (stb.eisFlip) statNext[ST_EIS] = ~statNext[ST_EIS];
    if (stb.detach) begin
      statNext[ST_PDS] = 1'b0;
      statNext[ST_PDC] = 1'b1;
    end
    if (stb.cmdDone) statNext[ST_CC] = 1'b1;
    if (stb.setAbp) statNext[ST_ABP] = 1'b1;
    if (stb.setPdc) statNext[ST_PDC] = 1'b1;
    if (stb.setPds) statNext[ST_PDS] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrlQ     <= devPresent ? CTRL_RST_FULL : CTRL_RST_EMPTY;
      statQ     <= REG_W'(devPresent) << ST_PDS;
      detachReq <= 1'b0;
    end else begin
      if (stb.ctrlLoad) ctrlQ <= stb.ctrlVal;
      statQ     <= statNext;
      detachReq <= stb.detach;
    end
  end

  generate
    if (HAS_LINK_RPT) begin : g_link
      logic linkQ;
      always_ff @(posedge clk) begin
        if (!rst_n)          linkQ <= devPresent;
        else if (stb.setPds) linkQ <= 1'b1;
        else if (stb.detach) linkQ <= 1'b0;
      end
      assign linkActive = linkQ;
    end else begin : g_nolink
      assign linkActive = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/hp_slot_ctl.sv
module hp_slot_ctl
  import hp_slot_pkg::*;
#(
  parameter bit HAS_PWR_CTL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [BE_W-1:0]   wrBe,
  input  logic              btnPress,
  input  logic              presChange,
  input  logic              devAdd,
  input  logic              msgMode,
  input  logic [REG_W-1:0]  ctrlQ,
  input  logic [REG_W-1:0]  statQ,
  output hpStrobe_t         stb,
  output logic              intLegacy,
  output logic              msgReq
);
  localparam logic [REG_W-1:0] WMASK_BASE = EV_MASK | (REG_W'(1) << CT_HPIE) |
    (REG_W'(3) << CT_AI_LO) | (REG_W'(3) << CT_PI_LO);
  localparam logic [REG_W-1:0] WMASK = HAS_PWR_CTL ?
    (WMASK_BASE | (REG_W'(1) << CT_PCC)) : WMASK_BASE;

  logic             ctrlTouch;
  logic             statTouch;
  logic [REG_W-1:0] merged;
  logic             notif;
  logic             notifQ;
  logic             statWrQ;
  logic             intQ;
  logic             msgQ;

  assign ctrlTouch = wrEn && (|wrBe[1:0]);
  assign statTouch = wrEn && (|wrBe[3:2]);

  generate
    for (genvar b = 0; b < REG_W / 8; b++) begin : g_merge
      assign merged[b*8 +: 8] = wrBe[b] ? wrData[b*8 +: 8] : ctrlQ[b*8 +: 8];
    end
  endgenerate

  always_comb begin
    stb          = '0;
    stb.ctrlLoad = ctrlTouch;
    stb.ctrlVal  = merged & WMASK;
    stb.cmdDone  = ctrlTouch;
    stb.eisFlip  = ctrlTouch && wrBe[1] && wrData[CT_EIC];
    stb.detach   = ctrlTouch && statQ[ST_PDS] && merged[CT_PCC] &&
                   (merged[CT_PI_LO +: 2] == IND_OFF);
    if (statTouch && wrBe[2]) stb.statClr = wrData[REG_W +: REG_W] & EV_MASK;
    stb.setAbp = btnPress || devAdd;
    stb.setPdc = presChange || devAdd;
    stb.setPds = devAdd;
  end

  assign notif = ctrlQ[CT_HPIE] && (|(statQ & ctrlQ & EV_MASK));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      notifQ  <= 1'b0;
      statWrQ <= 1'b0;
      intQ    <= 1'b0;
      msgQ    <= 1'b0;
    end else begin
      notifQ  <= notif;
      statWrQ <= statTouch;
      msgQ    <= msgMode && (notif != notifQ);
      if (!msgMode && (notif != notifQ)) intQ <= notif;
      else if (!msgMode && statWrQ && !notif) intQ <= 1'b0;
    end
  end

  assign intLegacy = intQ;
  assign msgReq    = msgQ;
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter bit HAS_PWR_CTL  = 1'b1,
  parameter bit HAS_LINK_RPT = 1'b1,
  parameter int VEC_W        = 5,
  parameter logic [VEC_W-1:0] MSG_VEC = 5'd9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              devPresent,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  input  logic [3:0]        wrBe,
  input  logic              btnPress,
  input  logic              presChange,
  input  logic              devAdd,
  input  logic              msgMode,
  output logic [31:0]       rdData,
  output logic              intLegacy,
  output logic              msgReq,
  output logic [VEC_W-1:0]  msgVector,
  output logic              detachReq,
  output logic              linkActive
);
  hpStrobe_t        stb;
  logic [REG_W-1:0] ctrlQ;
  logic [REG_W-1:0] statQ;

  hp_slot_ctl #(.HAS_PWR_CTL(HAS_PWR_CTL)) i_ctl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrData(wrData), .wrBe(wrBe),
    .btnPress(btnPress), .presChange(presChange), .devAdd(devAdd),
    .msgMode(msgMode), .ctrlQ(ctrlQ), .statQ(statQ), .stb(stb),
    .intLegacy(intLegacy), .msgReq(msgReq)
  );

  hp_slot_dp #(.HAS_PWR_CTL(HAS_PWR_CTL), .HAS_LINK_RPT(HAS_LINK_RPT)) i_dp (
    .clk(clk), .rst_n(rst_n), .devPresent(devPresent), .stb(stb),
    .ctrlQ(ctrlQ), .statQ(statQ), .linkActive(linkActive), .detachReq(detachReq)
  );

  assign rdData    = {statQ, ctrlQ};
  assign msgVector = MSG_VEC;
endmodule

// File: rtl/hp_slot_chk.sv
module hp_slot_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wrEn,
  input logic [31:0] wrData,
  input logic [3:0]  wrBe,
  input logic        devAdd,
  input logic        msgMode,
  input logic [31:0] rdData,
  input logic        intLegacy,
  input logic        msgReq,
  input logic        detachReq,
  input logic        linkActive
);
  AST_CMD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && (|wrBe[1:0])) |=> rdData[20]); // R1

  AST_EIS_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrBe[1] && wrData[11]) |=> (rdData[23] != $past(rdData[23]))); // R2

  AST_EIC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rdData[11]); // R2

  AST_INT_NEEDS_HPIE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intLegacy) |-> $past(rdData[5])); // R3

  AST_MSG_ONLY_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    msgReq |-> $past(msgMode)); // R4

  AST_LEGACY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(intLegacy)) |-> !$past(msgMode)); // R4

  AST_DETACH_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (detachReq && !$past(devAdd)) |-> (!rdData[22] && rdData[19] && !linkActive)); // R6
endmodule

bind hp_slot_ctrl hp_slot_chk i_hp_slot_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrData(wrData), .wrBe(wrBe),
  .devAdd(devAdd), .msgMode(msgMode), .rdData(rdData), .intLegacy(intLegacy),
  .msgReq(msgReq), .detachReq(detachReq), .linkActive(linkActive)
);

// File: tb/test_hp_slot_ctrl.sv
module test_hp_slot_ctrl;
  localparam logic [4:0] VEC = 5'd9;
  localparam logic [15:0] WM = 16'h07F9;
  localparam logic [15:0] EVM = 16'h0019;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic devPresent = 1'b1;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [3:0] wrBe = '0;
  logic btnPress = 1'b0, presChange = 1'b0, devAdd = 1'b0, msgMode = 1'b0;
  logic [31:0] rdData;
  logic intLegacy, msgReq, detachReq, linkActive;
  logic [4:0] msgVector;

  int checks = 0;
  int fails = 0;

  logic [15:0] mCtrl, mStat;
  logic mLink, mNotifQ, mInt, mMsg, mDet, mStatWrQ;

  always #2 clk = ~clk;

  hp_slot_ctrl i_hp_slot_ctrl (
    .clk(clk), .rst_n(rst_n), .devPresent(devPresent), .wrEn(wrEn),
    .wrData(wrData), .wrBe(wrBe), .btnPress(btnPress), .presChange(presChange),
    .devAdd(devAdd), .msgMode(msgMode), .rdData(rdData), .intLegacy(intLegacy),
    .msgReq(msgReq), .msgVector(msgVector), .detachReq(detachReq),
    .linkActive(linkActive)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic notifOf(input logic [15:0] c, input logic [15:0] s);
    return c[5] && (|(s & c & EVM));
  endfunction

  task automatic compareAll(input string tag);
    check({tag, " regs"}, rdData, {mStat, mCtrl});
    check({tag, " intLegacy"}, 32'(intLegacy), 32'(mInt));
    check({tag, " msgReq"}, 32'(msgReq), 32'(mMsg));
    check({tag, " detachReq"}, 32'(detachReq), 32'(mDet));
    check({tag, " linkActive"}, 32'(linkActive), 32'(mLink));
    check({tag, " msgVector R4"}, 32'(msgVector), 32'(VEC));
  endtask

  task automatic doReset(input logic present);
    rst_n = 1'b0; devPresent = present;
    wrEn = 0; wrBe = 0; wrData = 0; btnPress = 0; presChange = 0; devAdd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    mCtrl = present ? 16'h01C0 : 16'h07C0;
    mStat = present ? 16'h0040 : 16'h0000;
    mLink = present; mNotifQ = 0; mInt = 0; mMsg = 0; mDet = 0; mStatWrQ = 0;
  endtask

  // one cycle: drive at negedge, sample one ns after the rising edge
  task automatic step(input logic we, input logic [31:0] wd, input logic [3:0] be,
                      input logic bp, input logic pc, input logic da, input string tag);
    logic ct, st, eis, det, nOld, nInt;
    logic [15:0] mrg, w1c, s, nCtrl;
    logic nLink;
    wrEn = we; wrData = wd; wrBe = be; btnPress = bp; presChange = pc; devAdd = da;
    ct = we && (be[0] || be[1]);
    st = we && (be[2] || be[3]);
    mrg = {be[1] ? wd[15:8] : mCtrl[15:8], be[0] ? wd[7:0] : mCtrl[7:0]};
    nCtrl = ct ? (mrg & WM) : mCtrl;
    eis = ct && be[1] && wd[11];
    det = ct && mStat[6] && mrg[10] && (mrg[9:8] == 2'b11);
    w1c = (st && be[2]) ? ({8'h00, wd[23:16]} & EVM) : 16'h0000;
    s = mStat & ~w1c;
    if (eis) s[7] = ~s[7];
    if (det) begin s[6] = 1'b0; s[3] = 1'b1; end
    if (ct) s[4] = 1'b1;
    if (bp || da) s[0] = 1'b1;
    if (pc || da) s[3] = 1'b1;
    if (da) s[6] = 1'b1;
    nLink = da ? 1'b1 : (det ? 1'b0 : mLink);
    nOld = notifOf(mCtrl, mStat);
    nInt = mInt;
    if (!msgMode && (nOld != mNotifQ)) nInt = nOld;
    else if (!msgMode && mStatWrQ && !nOld) nInt = 1'b0;
    @(posedge clk);
    #1;
    mMsg = msgMode && (nOld != mNotifQ);
    mInt = nInt; mNotifQ = nOld; mStatWrQ = st;
    mCtrl = nCtrl; mStat = s; mLink = nLink; mDet = det;
    compareAll(tag);
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  logic intBefore;

  initial begin
    void'($urandom(32'h5EED_1234));
    doReset(1'b1);
    check("R7 populated reset regs", rdData, 32'h0040_01C0);
    check("R7 populated reset link", 32'(linkActive), 32'd1);
    check("R7 reset irq", {29'd0, intLegacy, msgReq, detachReq}, 32'd0);

    // R1 / R3: enable all events and HPIE through byte 0
    step(1'b1, 32'h0000_0039, 4'b0001, 0, 0, 0, "R1 ctrl write");
    check("R1 command completed", 32'(rdData[20]), 32'd1);
    idle("R3 settle");
    check("R3 legacy line high", 32'(intLegacy), 32'd1);

    // R8: clear command completed, line drops
    step(1'b1, 32'h0010_0000, 4'b0100, 0, 0, 0, "R8 w1c");
    check("R8 cc cleared", 32'(rdData[20]), 32'd0);
    idle("R8 settle");
    check("R8 legacy line low", 32'(intLegacy), 32'd0);

    // R2: interlock toggle twice
    step(1'b1, 32'h0000_0800, 4'b0010, 0, 0, 0, "R2 eic 1");
    check("R2 eis set", 32'(rdData[23]), 32'd1);
    check("R2 eic reads 0", 32'(rdData[11]), 32'd0);
    step(1'b1, 32'h0000_0800, 4'b0010, 0, 0, 0, "R2 eic 2");
    check("R2 eis cleared", 32'(rdData[23]), 32'd0);
    idle("R3 settle2");

    // R4 / R5: message mode
    intBefore = intLegacy;
    msgMode = 1'b1;
    step(1'b1, 32'h0019_0000, 4'b0100, 0, 0, 0, "R4 clear all");
    idle("R4 drop pulse");
    idle("R4 quiet");
    check("R4 no request when stable", 32'(msgReq), 32'd0);
    step(1'b0, 32'h0, 4'h0, 1, 0, 0, "R4 button");
    idle("R4 pulse");
    check("R4 message request", 32'(msgReq), 32'd1);
    check("R4 vector", 32'(msgVector), 32'(VEC));
    idle("R4 pulse end");
    check("R4 one cycle", 32'(msgReq), 32'd0);
    step(1'b0, 32'h0, 4'h0, 1, 0, 0, "R5 button again");
    check("R5 no request a", 32'(msgReq), 32'd0);
    idle("R5 after");
    check("R5 no request b", 32'(msgReq), 32'd0);
    check("R4 legacy unchanged", 32'(intLegacy), 32'(intBefore));

    // R6: detach on populated slot
    msgMode = 1'b0;
    idle("R6 prep");
    step(1'b1, 32'h0000_0700, 4'b0010, 0, 0, 0, "R6 power off");
    check("R6 detach pulse", 32'(detachReq), 32'd1);
    check("R6 present cleared", 32'(rdData[22]), 32'd0);
    check("R6 pdc set", 32'(rdData[19]), 32'd1);
    check("R6 link cleared", 32'(linkActive), 32'd0);
    idle("R6 end");
    check("R6 one cycle", 32'(detachReq), 32'd0);

    // R9: device added
    step(1'b1, 32'h0019_0000, 4'b0100, 0, 0, 0, "R9 clear");
    step(1'b0, 32'h0, 4'h0, 0, 0, 1, "R9 add");
    check("R9 status bits", 32'({rdData[22], rdData[19], rdData[16]}), 32'd7);
    check("R9 link", 32'(linkActive), 32'd1);

    // R10: separate events
    step(1'b1, 32'h0019_0000, 4'b0100, 0, 0, 0, "R10 clear");
    step(1'b0, 32'h0, 4'h0, 0, 1, 0, "R10 presence");
    check("R10 pdc only", 32'({rdData[19], rdData[16]}), 32'd2);
    step(1'b0, 32'h0, 4'h0, 1, 0, 0, "R10 button");
    check("R10 abp", 32'(rdData[16]), 32'd1);

    // R11: byte 1 untouched
    step(1'b1, 32'h0000_AAFF, 4'b0001, 0, 0, 0, "R11 byte0 only");
    check("R11 byte1 kept", 32'(rdData[15:8]), 32'h07);
    check("R11 byte0 masked", 32'(rdData[7:0]), 32'hF9);

    // R7: empty-slot reset also clears interlock status
    step(1'b1, 32'h0000_0800, 4'b0010, 0, 0, 0, "R7 set eis");
    doReset(1'b0);
    check("R7 empty reset regs", rdData, 32'h0000_07C0);
    check("R7 empty reset link", 32'(linkActive), 32'd0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] rbe;
      logic rwe;
      logic [31:0] rwd;
      if ($urandom_range(0, 99) < 3) msgMode = ~msgMode;
      rwe = ($urandom_range(0, 3) == 0);
      rbe = 4'($urandom);
      rwd = $urandom;
      if ($urandom_range(0, 3) == 0) rwd[10:8] = 3'b111;
      step(rwe, rwd, rbe, ($urandom_range(0, 7) == 0), ($urandom_range(0, 9) == 0),
           ($urandom_range(0, 15) == 0), "R3 R4 R6 R8 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule